// File: doc/BRIEF.md
# Power-Up Link Mode Selector

This block settles, once per power cycle, which serial link a secure memory device uses. From the moment power-good rises it watches the reset, clock and data pins. If it finds reset high, it arms the synchronous two-wire path. That path reports ready after a short warm-up of clock edges. If reset, clock and data are all low, the block waits through a cold-reset sequence. In that sequence the host clocks the device and then raises reset. When enough clocks have passed, the block latches the asynchronous mode and shifts out a fixed answer-to-reset (ATR) word before reporting ready.

The asynchronous choice, and an invalid cold reset, can only be undone by removing power-good. A power-good drop clears every counter and the mode latch. The pins are synchronised to the core clock inside the block. Pin edges are counted as synchronised rising levels.

Top module: `iface_mode_sel`

## Requirements
- R1: While `pwr_good_i` is low, `ready_o` is 0 in the same cycle. One clock later `mode_o` reads pending (2'b00) and `atr_oe_o` is 0.
- R2: When the reset pin reads high at the first powered sample, `mode_o` becomes synchronous (2'b01).
- R3: In synchronous mode, `ready_o` stays 0 after 4 rising edges of the clock pin and becomes 1 after the 5th.
- R4: With all three pins low at power-up, the block waits with `mode_o` pending and `atr_oe_o` 0, so the data pin is left in receive.
- R5: A reset-pin rise after at least 400 clock-pin rising edges selects asynchronous mode (2'b10) and starts the ATR. A clock edge in the same synchronised cycle as the reset rise counts toward the 400.
- R6: A reset-pin rise after fewer than 400 edges gives `mode_o` invalid (2'b11). No ATR is sent, and `ready_o` stays 0 until power is cycled.
- R7: The ATR sends bit 0 of `atr_word_i` first, so the least significant byte goes first, through bit 63. Each bit is held for `BIT_CYCLES` core clocks. `atr_oe_o` is high for exactly 64*`BIT_CYCLES` cycles, and `atr_bit_o` is 0 whenever `atr_oe_o` is 0.
- R8: `ready_o` rises in the cycle `atr_oe_o` falls. Asynchronous mode then stays latched whatever the reset pin does.
- R9: Synchronous mode stays latched whatever the reset pin does. `ready_o` and `atr_oe_o` are never high together.
- R10: After a power-good drop, a fresh power-up makes a fresh selection, for example synchronous after a previous asynchronous session.
- R11: If reset is low but clock or data is high at power-up, the block stays pending. It re-samples each cycle until one of the two start conditions holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply stable; low clears all selection state |
| pin_rst_i | input | 1 | Reset pin level |
| pin_clk_i | input | 1 | Link clock pin level |
| pin_data_i | input | 1 | Data pin level (receive direction) |
| atr_word_i | input | 64 | Answer-to-reset contents |
| mode_o | output | 2 | 00 pending, 01 synchronous, 10 asynchronous, 11 invalid |
| ready_o | output | 1 | Ready for first command |
| atr_bit_o | output | 1 | Serial ATR data |
| atr_oe_o | output | 1 | Data pin output enable during ATR |

## Verification
Two functions can land in the same synchronised cycle: the 400th clock-edge count and the reset-rise decision. The bench gives exactly 399 clock pulses, then raises the clock and reset pins at the same moment, so both pass through the synchronisers together. A correct design counts that edge and enters asynchronous mode. A second run with the same 399 pulses and a lone reset rise must give invalid. A power-good drop in the middle of an ATR is also provoked, and is judged on the immediate loss of ready and on the cleared mode one cycle later.

// File: rtl/iface_mode_pkg.sv
package iface_mode_pkg;

  typedef enum logic [1:0] {
    MODE_PENDING = 2'b00,
    MODE_SYNC    = 2'b01,
    MODE_ASYNC   = 2'b10,
    MODE_INVALID = 2'b11
  } link_mode_e;

  typedef enum logic [2:0] {
    ST_DECIDE,
    ST_WARM,
    ST_SYNC_RDY,
    ST_COLD,
    ST_ATR,
    ST_ASYNC_RDY,
    ST_BAD
  } sel_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N_PINS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] level_o,
  output logic [N_PINS-1:0] rise_o
);

  logic [N_PINS-1:0] stg [STAGES];
  logic [N_PINS-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_o;
  end

  assign level_o = stg[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import iface_mode_pkg::*;
#(
  parameter int COLD_CLKS  = 400,
  parameter int WARM_EDGES = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       rst_lvl_i,
  input  logic       rst_rise_i,
  input  logic       clk_lvl_i,
  input  logic       clk_rise_i,
  input  logic       data_lvl_i,
  input  logic       atr_done_i,
  output logic       atr_start_o,
  output logic [1:0] mode_o,
  output logic       ready_o
);

  localparam int CNT_MAX = (COLD_CLKS > WARM_EDGES) ? COLD_CLKS : WARM_EDGES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  sel_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_sat;

  // saturating count of synchronised clock-pin edges, including this cycle's
  assign cnt_sat = (cnt_q == CNT_W'(CNT_MAX)) ? cnt_q
                 : cnt_q + {{(CNT_W-1){1'b0}}, clk_rise_i};

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    atr_start_o = 1'b0;
    unique case (state_q)
      ST_DECIDE: begin
        cnt_d = '0;
        if (rst_lvl_i)                    state_d = ST_WARM;
        else if (!clk_lvl_i && !data_lvl_i) state_d = ST_COLD;
      end
      ST_WARM: begin
        cnt_d = cnt_sat;
        if (cnt_sat >= CNT_W'(WARM_EDGES)) state_d = ST_SYNC_RDY;
      end
      ST_COLD: begin
        cnt_d = cnt_sat;
        if (rst_rise_i) begin
          if (cnt_sat >= CNT_W'(COLD_CLKS)) begin
            state_d     = ST_ATR;
            atr_start_o = 1'b1;
          end else begin
            state_d = ST_BAD;
          end
        end
      end
      ST_ATR: if (atr_done_i) state_d = ST_ASYNC_RDY;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DECIDE;
      cnt_q   <= '0;
    end else if (!pwr_good_i) begin
      state_q <= ST_DECIDE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_WARM, ST_SYNC_RDY: mode_o = MODE_SYNC;
      ST_ATR, ST_ASYNC_RDY: mode_o = MODE_ASYNC;
      ST_BAD:               mode_o = MODE_INVALID;
      default:              mode_o = MODE_PENDING;
    endcase
  end

  assign ready_o = (state_q == ST_SYNC_RDY) || (state_q == ST_ASYNC_RDY);

endmodule

// File: rtl/atr_shifter.sv
module atr_shifter #(
  parameter int W          = 64,
  parameter int BIT_CYCLES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o,
  output logic         oe_o,
  output logic         done_o
);

  localparam int TICK_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int IDX_W  = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]      sh_q;
  logic              busy_q;
  logic [TICK_W-1:0] tick_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_tick, last_bit;

  assign last_tick = (tick_q == TICK_W'(BIT_CYCLES - 1));
  assign last_bit  = (idx_q == IDX_W'(W - 1));
  assign done_o    = busy_q & last_tick & last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      busy_q <= 1'b0;
      tick_q <= '0;
      idx_q  <= '0;
    end else if (clear_i) begin
      sh_q   <= '0;
      busy_q <= 1'b0;
      tick_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      sh_q   <= word_i;
      busy_q <= 1'b1;
      tick_q <= '0;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (last_tick) begin
        tick_q <= '0;
        sh_q   <= sh_q >> 1;
        if (last_bit) busy_q <= 1'b0;
        else          idx_q  <= idx_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign oe_o  = busy_q;
  assign bit_o = busy_q & sh_q[0];

endmodule

// File: rtl/iface_mode_sel.sv
module iface_mode_sel #(
  parameter int ATR_W       = 64,
  parameter int COLD_CLKS   = 400,
  parameter int WARM_EDGES  = 5,
  parameter int BIT_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             pin_rst_i,
  input  logic             pin_clk_i,
  input  logic             pin_data_i,
  input  logic [ATR_W-1:0] atr_word_i,
  output logic [1:0]       mode_o,
  output logic             ready_o,
  output logic             atr_bit_o,
  output logic             atr_oe_o
);

  localparam int N_PINS = 3;
  localparam int P_RST  = 0;
  localparam int P_CLK  = 1;
  localparam int P_DAT  = 2;

  logic [N_PINS-1:0] lvl, rise;
  logic              atr_start, atr_done, ready_q;

  pin_sync #(
    .N_PINS (N_PINS),
    .STAGES (SYNC_STAGES)
  ) i_pin_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   ({pin_data_i, pin_clk_i, pin_rst_i}),
    .level_o (lvl),
    .rise_o  (rise)
  );

  mode_fsm #(
    .COLD_CLKS  (COLD_CLKS),
    .WARM_EDGES (WARM_EDGES)
  ) i_mode_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_good_i  (pwr_good_i),
    .rst_lvl_i   (lvl[P_RST]),
    .rst_rise_i  (rise[P_RST]),
    .clk_lvl_i   (lvl[P_CLK]),
    .clk_rise_i  (rise[P_CLK]),
    .data_lvl_i  (lvl[P_DAT]),
    .atr_done_i  (atr_done),
    .atr_start_o (atr_start),
    .mode_o      (mode_o),
    .ready_o     (ready_q)
  );

  atr_shifter #(
    .W          (ATR_W),
    .BIT_CYCLES (BIT_CYCLES)
  ) i_atr_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!pwr_good_i),
    .start_i (atr_start),
    .word_i  (atr_word_i),
    .bit_o   (atr_bit_o),
    .oe_o    (atr_oe_o),
    .done_o  (atr_done)
  );

  assign ready_o = ready_q & pwr_good_i;

endmodule

// File: rtl/iface_mode_sel_chk.sv
module iface_mode_sel_chk
  import iface_mode_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic [1:0] mode_o,
  input logic       ready_o,
  input logic       atr_bit_o,
  input logic       atr_oe_o
);

  // R1
  pwr_low_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !ready_o);

  // R1
  pwr_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (mode_o == MODE_PENDING && !atr_oe_o));

  // R8
  async_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_o == MODE_ASYNC) |=> mode_o == MODE_ASYNC);

  // R9
  sync_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_o == MODE_SYNC) |=> mode_o == MODE_SYNC);

  // R6
  invalid_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_o == MODE_INVALID) |=> (mode_o == MODE_INVALID && !ready_o));

  // R9
  ready_oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && atr_oe_o));

  // R7
  oe_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atr_oe_o |-> mode_o == MODE_ASYNC);

  // R7
  bit_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atr_bit_o |-> atr_oe_o);

endmodule

bind iface_mode_sel iface_mode_sel_chk i_chk (.*);

// File: tb/test_iface_mode_sel.sv
module test_iface_mode_sel;

  localparam int BC = 4;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_good = 1'b0;
  logic          pin_rst = 1'b0;
  logic          pin_clk = 1'b0;
  logic          pin_data = 1'b0;
  logic [AW-1:0] atr_word = '0;
  logic [1:0]    mode;
  logic          ready, atr_bit, atr_oe;

  int vectors = 0;
  int fails   = 0;

  always #10 clk = ~clk;

  iface_mode_sel #(
    .ATR_W      (AW),
    .COLD_CLKS  (400),
    .WARM_EDGES (5),
    .BIT_CYCLES (BC)
  ) i_iface_mode_sel (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pwr_good_i (pwr_good),
    .pin_rst_i  (pin_rst),
    .pin_clk_i  (pin_clk),
    .pin_data_i (pin_data),
    .atr_word_i (atr_word),
    .mode_o     (mode),
    .ready_o    (ready),
    .atr_bit_o  (atr_bit),
    .atr_oe_o   (atr_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up(input logic r, input logic c, input logic d);
    @(negedge clk);
    pwr_good = 1'b0;
    pin_rst = r; pin_clk = c; pin_data = d;
    cyc(4);
    pwr_good = 1'b1;
    cyc(4);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin_clk = 1'b1; cyc(2);
      pin_clk = 1'b0; cyc(2);
    end
    cyc(4);
  endtask

  task automatic wait_oe(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 12 && !seen; i++) begin
      cyc(1);
      if (atr_oe) seen = 1'b1;
    end
  endtask

  // Sample a full ATR starting at the first negedge with oe high
  task automatic check_atr(input logic [AW-1:0] word);
    int bad = 0;
    int oe_len = 0;
    logic first_act = 1'b0, first_exp = 1'b0;
    for (int k = 0; k < AW * BC; k++) begin
      if (atr_oe) oe_len++;
      if (atr_bit !== word[k / BC] && bad == 0) begin
        first_act = atr_bit; first_exp = word[k / BC];
      end
      if (atr_bit !== word[k / BC]) bad++;
      cyc(1);
    end
    chk(bad == 0, "R7 bit order", first_act, first_exp);
    chk(oe_len == AW * BC, "R7 oe length", oe_len, AW * BC);
    chk(!atr_oe && !atr_bit, "R7 oe off after word", {atr_oe, atr_bit}, 0);
    chk(ready, "R8 ready at oe fall", ready, 1);
  endtask

  task automatic t_reset;
    cyc(3);
    chk(mode == 2'b00 && !ready && !atr_oe && !atr_bit, "R1 reset state",
        {mode, ready, atr_oe, atr_bit}, 0);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_sync;
    int ok = 1;
    power_up(1'b1, 1'b0, 1'b0);
    chk(mode == 2'b01, "R2 sync selected", mode, 1);
    chk(!ready, "R3 not ready before edges", ready, 0);
    pulses(4);
    chk(!ready, "R3 not ready after 4 edges", ready, 0);
    pulses(1);
    chk(ready, "R3 ready after 5 edges", ready, 1);
    pin_rst = 1'b0; cyc(6);
    pin_rst = 1'b1; cyc(6);
    chk(mode == 2'b01 && ready, "R9 sync latched over reset toggle", {mode, ready}, 3'b011);
    for (int i = 0; i < 10; i++) begin
      if (atr_oe) ok = 0;
      cyc(1);
    end
    chk(ok == 1, "R9 no ATR in sync mode", ok, 1);
  endtask

  task automatic t_pending_invalid;
    power_up(1'b0, 1'b1, 1'b0);
    cyc(6);
    chk(mode == 2'b00 && !atr_oe, "R11 pending with clock high", {mode, atr_oe}, 0);
    pin_clk = 1'b0;
    cyc(6);
    pin_data = 1'b1;
    pulses(10);
    chk(mode == 2'b00 && !atr_oe, "R4 cold wait undriven", {mode, atr_oe}, 0);
    pin_rst = 1'b1;
    cyc(8);
    chk(mode == 2'b11, "R6 short cold reset invalid", mode, 3);
    chk(!ready && !atr_oe, "R6 no ATR no ready", {ready, atr_oe}, 0);
    pin_rst = 1'b0; cyc(6);
    pin_rst = 1'b1; cyc(6);
    chk(mode == 2'b11 && !ready, "R6 invalid latched", {mode, ready}, 3'b110);
  endtask

  task automatic t_cold_ok;
    bit seen;
    atr_word = 64'hA5C3_1F80_0E7B_9D24;
    power_up(1'b0, 1'b0, 1'b0);
    pulses(400);
    chk(mode == 2'b00 && !atr_oe, "R4 pending until reset rise", {mode, atr_oe}, 0);
    pin_rst = 1'b1;
    wait_oe(seen);
    chk(seen, "R5 ATR starts after 400 edges", seen, 1);
    chk(mode == 2'b10, "R5 async selected", mode, 2);
    if (seen) check_atr(64'hA5C3_1F80_0E7B_9D24);
    pin_rst = 1'b0; cyc(6);
    chk(mode == 2'b10 && ready, "R8 async latched over reset drop", {mode, ready}, 3'b101);
    power_up(1'b1, 1'b0, 1'b0);
    chk(mode == 2'b01, "R10 new selection after power cycle", mode, 1);
  endtask

  task automatic t_coincide;
    bit seen;
    atr_word = 64'h0123_4567_89AB_CDEF;
    power_up(1'b0, 1'b0, 1'b0);
    pulses(399);
    pin_clk = 1'b1; pin_rst = 1'b1;
    wait_oe(seen);
    chk(seen && mode == 2'b10, "R5 edge coincident with reset counts", {seen, mode}, 3'b110);
    cyc(20);
    chk(atr_oe && !ready, "R9 mid ATR not ready", {atr_oe, ready}, 2'b10);
    pwr_good = 1'b0;
    #1;
    chk(!ready, "R1 ready drops with power-good", ready, 0);
    cyc(1);
    chk(mode == 2'b00 && !atr_oe, "R1 cleared next cycle", {mode, atr_oe}, 0);
    pin_clk = 1'b0;
    power_up(1'b0, 1'b0, 1'b0);
    pulses(399);
    pin_rst = 1'b1;
    cyc(8);
    chk(mode == 2'b11 && !atr_oe, "R6 399 edges then lone reset rise", {mode, atr_oe}, 3'b110);
  endtask

  initial begin
    t_reset();
    t_sync();
    t_pending_invalid();
    t_cold_ok();
    t_coincide();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule